// File: doc/BRIEF.md
# Flow-Control Pause Frame Generator

This block builds a full-duplex flow-control request frame on demand and streams it into a 32-bit word packet interface. A host asserts a one-cycle request together with a 16-bit pause quantum. The block then offers a fixed 60-byte frame, one word per accepted write, to a downstream sink such as a transmit FIFO. The sink exposes a write-available signal. Each word carries start and end markers and a 2-bit byte-count field.

The frame holds the reserved flow-control multicast destination 01-80-C2-00-00-01, an all-zero source address, the control EtherType 0x8808, the pause opcode 0x0001, the pause quantum, and zero padding up to 60 bytes. Bytes are packed big-endian, so the first byte on the wire sits in bits 31:24 of each word. Checksum, preamble and line coding are added further down the transmit path.

A request that arrives while a frame is still being written is held and served right after that frame's last word. Several such requests collapse into one follow-up frame, which carries the most recent quantum. A busy flag lets the host see that a request is being served.

Top module: `pause_frame_gen`

## Requirements
- R1: While reset is held and after its release with no request, `busy_o` and `wr_o` are low, even if `req_i` and `sink_ready_i` are high during reset.
- R2: A request taken while idle raises `busy_o` in the next cycle. The first word is offered in that same next cycle if `sink_ready_i` is high.
- R3: A frame is exactly 15 written words. `sop_o` is 1 only on word 0 and `eop_o` is 1 only on word 14. `be_o` is 2'b00 on every word, which means all four bytes are valid.
- R4: Word 0 is 0x0180C200, word 1 is 0x00010000 and word 2 is 0x00000000. These carry the destination address and the zero source address, big-endian.
- R5: Word 3 is 0x88080001, the control type followed by the pause opcode.
- R6: Word 4 is {quantum, 16'h0000}. The quantum is sampled in the cycle the request is taken, and later changes on `pause_time_i` do not alter the frame.
- R7: Words 5 to 14 are all zero.
- R8: `wr_o` is high only while `sink_ready_i` is high and a frame is in progress. While the sink is not ready the word index holds, so no word is skipped or repeated.
- R9: A request taken during a frame, including in the cycle its last word is written, starts a new frame in the cycle after that last word. The new frame uses the quantum of the latest such request.
- R10: With no request pending, `busy_o` falls in the cycle after the end-of-packet word is written.
- R11: Any number of requests during one frame produce exactly one follow-up frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | One-cycle request for a pause frame |
| pause_time_i | input | 16 | Pause quantum sampled with the request |
| sink_ready_i | input | 1 | Sink can take a word this cycle |
| wr_o | output | 1 | Word on the outputs is written this cycle |
| data_o | output | 32 | Frame word, first wire byte in bits 31:24 |
| be_o | output | 2 | Valid-byte code, 00 means four bytes |
| sop_o | output | 1 | First word of the frame |
| eop_o | output | 1 | Last word of the frame |
| busy_o | output | 1 | A frame is being offered |

## Verification
A request changes `busy_o` one clock edge later. From that cycle on, `wr_o`, the data and the markers follow combinationally from the registered index and the current `sink_ready_i`, with no further delay. The bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. It compares each cycle's outputs with a cycle-level model of the requirements, stepped once per rising edge. Directed runs measure the cycle distance between a request and the first word, and between an end-of-packet word and the next start-of-packet word.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned QUANT_W = 16;
    localparam int unsigned BE_W    = 2;

    localparam logic [WORD_W-1:0]  DST_HEAD   = 32'h0180_C200;
    localparam logic [15:0]        DST_TAIL   = 16'h0001;
    localparam logic [WORD_W-1:0]  CTRL_WORD  = 32'h8808_0001;
    localparam logic [BE_W-1:0]    BE_ALL     = 2'b00;
endpackage

// File: rtl/pfg_word_map.sv
module pfg_word_map
    import pfg_pkg::*;
#(
    parameter int unsigned WORDS = 15,
    parameter int unsigned IDX_W = 4
) (
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [QUANT_W-1:0] quant_i,
    output logic [WORD_W-1:0]  data_o,
    output logic               sop_o,
    output logic               eop_o,
    output logic [BE_W-1:0]    be_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    always_comb begin
        data_o = '0;
        unique case (idx_i)
            IDX_W'(0): data_o = DST_HEAD;
            IDX_W'(1): data_o = {DST_TAIL, 16'h0000};
            IDX_W'(3): data_o = CTRL_WORD;
            IDX_W'(4): data_o = {quant_i, {(WORD_W-QUANT_W){1'b0}}};
            default:   data_o = '0;
        endcase
        sop_o = (idx_i == '0);
        eop_o = (idx_i == LAST_IDX);
        be_o  = BE_ALL;
    end
endmodule

// File: rtl/pfg_seq.sv
module pfg_seq
    import pfg_pkg::*;
#(
    parameter int unsigned WORDS = 15,
    parameter int unsigned IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [QUANT_W-1:0] quant_i,
    input  logic               ready_i,
    output logic               wr_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [QUANT_W-1:0] quant_o,
    output logic               busy_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    typedef struct packed {
        logic               active;
        logic               pend;
        logic [IDX_W-1:0]   idx;
        logic [QUANT_W-1:0] quant;
        logic [QUANT_W-1:0] pend_quant;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       take;
    logic       last_take;

    always_comb begin
        st_d      = st_q;
        take      = st_q.active && ready_i;
        last_take = take && (st_q.idx == LAST_IDX);

        if (!st_q.active) begin
            if (req_i) begin
                st_d.active = 1'b1;
                st_d.idx    = '0;
                st_d.quant  = quant_i;
            end
        end else if (last_take) begin
            if (req_i || st_q.pend) begin
                st_d.idx   = '0;
                st_d.quant = req_i ? quant_i : st_q.pend_quant;
                st_d.pend  = 1'b0;
            end else begin
                st_d.active = 1'b0;
            end
        end else begin
            if (take) begin
                st_d.idx = st_q.idx + 1'b1;
            end
            if (req_i) begin
                st_d.pend       = 1'b1;
                st_d.pend_quant = quant_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_o    = take;
    assign idx_o   = st_q.idx;
    assign quant_o = st_q.quant;
    assign busy_o  = st_q.active;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !ready_i) |=> $stable(st_q.idx)); // R8
    AST_BUSY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_o) |=> busy_o); // R2
    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && (idx_o == LAST_IDX) && !st_q.pend && !req_i) |=> !busy_o); // R10
    AST_RESTART_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && (idx_o == LAST_IDX) && (st_q.pend || req_i)) |=> (busy_o && idx_o == '0)); // R9
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
    import pfg_pkg::*;
#(
    parameter int unsigned FRAME_BYTES = 60
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [15:0]        pause_time_i,
    input  logic               sink_ready_i,
    output logic               wr_o,
    output logic [31:0]        data_o,
    output logic [1:0]         be_o,
    output logic               sop_o,
    output logic               eop_o,
    output logic               busy_o
);
    localparam int unsigned WORDS = FRAME_BYTES / (WORD_W / 8);
    localparam int unsigned IDX_W = $clog2(WORDS);

    logic [IDX_W-1:0]   idx;
    logic [QUANT_W-1:0] quant;

    pfg_seq #(.WORDS(WORDS), .IDX_W(IDX_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .quant_i (pause_time_i),
        .ready_i (sink_ready_i),
        .wr_o    (wr_o),
        .idx_o   (idx),
        .quant_o (quant),
        .busy_o  (busy_o)
    );

    pfg_word_map #(.WORDS(WORDS), .IDX_W(IDX_W)) u_map (
        .idx_i   (idx),
        .quant_i (quant),
        .data_o  (data_o),
        .sop_o   (sop_o),
        .eop_o   (eop_o),
        .be_o    (be_o)
    );

    AST_MARKERS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> !(sop_o && eop_o)); // R3
    AST_SOP_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && eop_o) |=> (!wr_o || sop_o)); // R9
    AST_WR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> (sink_ready_i && busy_o)); // R8
endmodule

// File: tb/pause_frame_gen_tb.sv
module pause_frame_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] ptime = '0;
    logic        ready = 1'b0;
    logic        wr_o, sop_o, eop_o, busy_o;
    logic [31:0] data_o;
    logic [1:0]  be_o;

    always #2 clk = ~clk;

    pause_frame_gen u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .pause_time_i(ptime),
        .sink_ready_i(ready), .wr_o(wr_o), .data_o(data_o), .be_o(be_o),
        .sop_o(sop_o), .eop_o(eop_o), .busy_o(busy_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    // bench model of the requirements
    bit        m_act = 0, m_pend = 0;
    int        m_cnt = 0;
    logic [15:0] m_q = '0, m_pq = '0;

    int n_eop = 0, last_eop_cyc = -100, sop_gap = 0, last_req_cyc = 0, first_wr_cyc = 0;
    logic [31:0] w4_last = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] exp_word(input int i, input logic [15:0] q);
        case (i)
            0: return 32'h0180C200;
            1: return 32'h00010000;
            3: return 32'h88080001;
            4: return {q, 16'h0000};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string word_tag(input int i);
        if (i <= 2) return "R4";
        if (i == 3) return "R5";
        if (i == 4) return "R6";
        return "R7";
    endfunction

    task automatic cycle(input bit r, input logic [15:0] p, input bit rdy);
        bit exp_wr;
        @(negedge clk);
        req = r; ptime = p; ready = rdy;
        #1;
        exp_wr = m_act && rdy;
        chk(wr_o == exp_wr, "R8 wr", 32'(wr_o), 32'(exp_wr));
        chk(busy_o == m_act, "R10 busy", 32'(busy_o), 32'(m_act));
        if (exp_wr && wr_o) begin
            chk(data_o == exp_word(m_cnt, m_q), word_tag(m_cnt), data_o, exp_word(m_cnt, m_q));
            chk(sop_o == (m_cnt == 0), "R3 sop", 32'(sop_o), 32'(m_cnt == 0));
            chk(eop_o == (m_cnt == 14), "R3 eop", 32'(eop_o), 32'(m_cnt == 14));
            chk(be_o == 2'b00, "R3 be", 32'(be_o), 32'h0);
        end
        if (wr_o && sop_o) begin sop_gap = cyc - last_eop_cyc; first_wr_cyc = cyc; end
        if (wr_o && eop_o) begin n_eop++; last_eop_cyc = cyc; end
        if (wr_o && m_cnt == 4) w4_last = data_o;
        if (r) last_req_cyc = cyc;
        // model update at the rising edge
        if (!m_act) begin
            if (r) begin m_act = 1; m_cnt = 0; m_q = p; end
        end else if (rdy && m_cnt == 14) begin
            if (r || m_pend) begin m_cnt = 0; m_q = r ? p : m_pq; m_pend = 0; end
            else m_act = 0;
        end else begin
            if (rdy) m_cnt++;
            if (r) begin m_pend = 1; m_pq = p; end
        end
        cyc++;
    endtask

    task automatic drain();
        for (int k = 0; k < 200 && m_act; k++) cycle(0, 16'h0, 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1: reset with request and ready high
        @(negedge clk); req = 1; ready = 1; ptime = 16'hFFFF;
        #1;
        chk(!busy_o && !wr_o, "R1 in reset", {busy_o, wr_o}, 0);
        @(negedge clk); rst_n = 1'b1; req = 0;
        #1;
        chk(!busy_o && !wr_o, "R1 after reset", {busy_o, wr_o}, 0);

        // R2, R6: idle request; quantum input changes afterwards
        cycle(1, 16'h1234, 1);
        for (int k = 0; k < 16; k++) cycle(0, 16'(k * 7 + 1), 1);
        chk(first_wr_cyc == last_req_cyc + 1, "R2 first word", 32'(first_wr_cyc), 32'(last_req_cyc + 1));
        chk(w4_last == 32'h12340000, "R6 held quantum", w4_last, 32'h12340000);
        chk(n_eop == 1, "R3 one frame", 32'(n_eop), 1);

        // R8: stalls inside a frame
        cycle(1, 16'h00AA, 0);
        for (int k = 0; k < 40; k++) cycle(0, 16'h0, (k % 3) == 1);
        drain();
        chk(n_eop == 2, "R8 frame completes", 32'(n_eop), 2);
        chk(w4_last == 32'h00AA0000, "R8 quantum", w4_last, 32'h00AA0000);

        // R9, R11: several requests during a frame, last one wins
        cycle(1, 16'h0101, 1);
        cycle(0, 16'h0, 1);
        cycle(1, 16'h0202, 1);
        cycle(0, 16'h0, 1);
        cycle(1, 16'h0303, 1);
        drain();
        chk(n_eop == 4, "R11 one follow-up frame", 32'(n_eop), 4);
        chk(sop_gap == 1, "R9 back-to-back", 32'(sop_gap), 1);
        chk(w4_last == 32'h03030000, "R9 latest quantum", w4_last, 32'h03030000);

        // R9: request in the cycle of the end-of-packet word
        cycle(1, 16'h0BEE, 1);
        for (int k = 0; k < 14; k++) cycle(0, 16'h0, 1);
        cycle(1, 16'h0CAF, 1);
        drain();
        chk(n_eop == 6, "R9 request at eop", 32'(n_eop), 6);
        chk(w4_last == 32'h0CAF0000, "R9 eop quantum", w4_last, 32'h0CAF0000);

        // R10: busy drops right after eop
        cycle(0, 16'h0, 1);
        chk(!busy_o, "R10 idle", 32'(busy_o), 0);

        // random mix
        for (int k = 0; k < 3000; k++)
            cycle(($urandom % 40) == 0, 16'($urandom), ($urandom % 4) != 0);
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule